// File: doc/BRIEF.md
# SD Multi-Block Data Transfer Sequencer with Automatic Stop

This block runs the data-line phase of an SD card transfer once the command that opens it has been accepted. At a start pulse it captures the transfer setup: whether data moves on the data lines at all, whether the transfer covers one block or many, which way the data flows, whether a stop command is to be sent without software help, and how many blocks a multi-block transfer contains. It then tells the data engine to run, with the captured direction. It counts the block-finished pulses the data engine reports.

When the last block of a multi-block transfer finishes and automatic stop was requested, the block asks the command path for a stop command. That command is index 12, with a zero argument and a 48-bit response that is followed by a busy check. It waits for that command's response-done pulse before it reports completion. A single-block transfer never produces a stop request, whatever the automatic-stop setting. A start that arrives while a transfer is still in progress is refused with an error pulse. Serial shifting, CRC and buffering belong to other blocks.

The controller has four states. IDLE waits for a start. DATA keeps the data engine running. STOP holds the stop-command request. FINISH lasts one cycle and reports completion. The transitions are as follows. IDLE goes to FINISH on a start with no data, or on a multi-block start with a zero count. IDLE goes to DATA on any other start. DATA goes to STOP on the last block when the transfer is multi-block with automatic stop. DATA goes to FINISH on the last block in every other case. STOP goes to FINISH on the response-done pulse. FINISH always goes back to IDLE.

Top module: `xfer_seq`

## Requirements
- R1: After reset, and with no start applied, data_active_o, stop_req_o, xfer_done_o and start_err_o are all 0.
- R2: A start with data_present_i = 0 never raises data_active_o or stop_req_o. xfer_done_o is 1 in the cycle after the start edge.
- R3: A start with multi_blk_i = 0 ignores blk_count_i. Exactly one blk_done_i pulse ends the transfer.
- R4: dir_read_o (1 = card to host, 0 = host to card) equals read_dir_i as sampled at the accepted start. It holds that value while data_active_o is 1, even if read_dir_i changes.
- R5: In a multi-block transfer with count N > 0, data_active_o stays 1 until the N-th blk_done_i pulse and falls in the cycle after that pulse. Each pulse lowers the remaining count by one.
- R6: In a multi-block transfer with auto_stop_i = 1, stop_req_o rises in the cycle after the last blk_done_i pulse. It stays 1 until cmd_rsp_done_i is sampled. While it is 1, stop_idx_o = 12, stop_arg_o = 0 and stop_rsp_o = 2'b11 (48-bit response with busy).
- R7: A single-block transfer never raises stop_req_o, even with auto_stop_i = 1.
- R8: xfer_done_o is a one-cycle pulse. With automatic stop it comes in the cycle after cmd_rsp_done_i is sampled. Without automatic stop it comes in the cycle after the last blk_done_i.
- R9: A multi-block start with blk_count_i = 0 gives xfer_done_o in the next cycle. It gives no data_active_o and no stop_req_o.
- R10: A start sampled while data_active_o, stop_req_o or xfer_done_o is 1 is refused. start_err_o pulses for one cycle, and the transfer in progress, including its direction and count, is unchanged.
- R11: blk_done_i outside DATA and cmd_rsp_done_i outside STOP have no effect on outputs or on the block count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a new transfer |
| data_present_i | input | 1 | 1 = transfer uses the data lines |
| multi_blk_i | input | 1 | 1 = multi-block, 0 = single block |
| read_dir_i | input | 1 | 1 = read (card to host), 0 = write |
| auto_stop_i | input | 1 | 1 = send stop command after last block |
| blk_count_i | input | CNT_W | Blocks in a multi-block transfer |
| blk_done_i | input | 1 | Block-finished pulse from the data engine |
| cmd_rsp_done_i | input | 1 | Stop command response-done pulse |
| data_active_o | output | 1 | Data engine run enable |
| dir_read_o | output | 1 | Captured direction for the data engine |
| stop_req_o | output | 1 | Request to the command path for the stop command |
| stop_idx_o | output | 6 | Stop command index |
| stop_arg_o | output | 32 | Stop command argument |
| stop_rsp_o | output | 2 | Stop command response type |
| xfer_done_o | output | 1 | Transfer complete pulse |
| start_err_o | output | 1 | Refused-start pulse |

## Verification
The bench builds the block with CNT_W = 4. With that width the largest count, 15, can be walked to its end block by block in a few dozen cycles. The same small width makes the zero count and the count of one easy to reach next to it. The table covers every combination of data-present, block mode, direction and automatic stop that changes the path through the states. Directed tests then cover refused starts during DATA and STOP, stray completion pulses, and a direction change in the middle of a transfer.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_STOP,
        ST_FINISH
    } seq_state_e;

    localparam int          CMD_IDX_W    = 6;
    localparam int          CMD_ARG_W    = 32;
    localparam logic [5:0]  STOP_CMD_IDX = 6'd12;
    localparam logic [1:0]  RSP_R48_BUSY = 2'b11;
endpackage

// File: rtl/xfer_seq_cfg.sv
module xfer_seq_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic multi_i,
    input  logic dir_i,
    input  logic auto_i,
    output logic multi_o,
    output logic dir_o,
    output logic auto_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            multi_o <= 1'b0;
            dir_o   <= 1'b0;
            auto_o  <= 1'b0;
        end else if (load_i) begin
            multi_o <= multi_i;
            dir_o   <= dir_i;
            auto_o  <= auto_i;
        end
    end
endmodule

// File: rtl/xfer_seq_cnt.sv
module xfer_seq_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load_i) begin
            remain_q <= load_val_i;
        end else if (dec_i && remain_q != '0) begin
            remain_q <= remain_q - ONE;
        end
    end

    assign last_o = (remain_q == ONE);
endmodule

// File: rtl/xfer_seq_fsm.sv
module xfer_seq_fsm
    import xfer_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic data_present_i,
    input  logic multi_blk_i,
    input  logic count_zero_i,
    input  logic blk_done_i,
    input  logic rsp_done_i,
    input  logic last_blk_i,
    input  logic cfg_multi_i,
    input  logic cfg_auto_i,
    output logic load_o,
    output logic dec_o,
    output logic data_active_o,
    output logic stop_req_o,
    output logic done_o,
    output logic err_o
);
    seq_state_e state_q, state_d;
    logic       busy;

    assign busy = (state_q != ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (!data_present_i)                 state_d = ST_FINISH;
                    else if (multi_blk_i && count_zero_i) state_d = ST_FINISH;
                    else                                  state_d = ST_DATA;
                end
            end
            ST_DATA: begin
                if (blk_done_i && last_blk_i) begin
                    if (cfg_multi_i && cfg_auto_i) state_d = ST_STOP;
                    else                           state_d = ST_FINISH;
                end
            end
            ST_STOP: begin
                if (rsp_done_i) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_o   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_o   <= start_i && busy;
        end
    end

    // outputs
    always_comb begin
        data_active_o = 1'b0;
        stop_req_o    = 1'b0;
        done_o        = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_DATA:   data_active_o = 1'b1;
            ST_STOP:   stop_req_o    = 1'b1;
            ST_FINISH: done_o        = 1'b1;
            default:   ;
        endcase
    end

    assign load_o = start_i && !busy && data_present_i;
    assign dec_o  = (state_q == ST_DATA) && blk_done_i;
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 data_present_i,
    input  logic                 multi_blk_i,
    input  logic                 read_dir_i,
    input  logic                 auto_stop_i,
    input  logic [CNT_W-1:0]     blk_count_i,
    input  logic                 blk_done_i,
    input  logic                 cmd_rsp_done_i,
    output logic                 data_active_o,
    output logic                 dir_read_o,
    output logic                 stop_req_o,
    output logic [CMD_IDX_W-1:0] stop_idx_o,
    output logic [CMD_ARG_W-1:0] stop_arg_o,
    output logic [1:0]           stop_rsp_o,
    output logic                 xfer_done_o,
    output logic                 start_err_o
);
    localparam logic [CNT_W-1:0] SINGLE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic             load, dec, last_blk;
    logic             cfg_multi, cfg_auto;
    logic [CNT_W-1:0] load_val;

    assign load_val = multi_blk_i ? blk_count_i : SINGLE;

    xfer_seq_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .multi_i (multi_blk_i),
        .dir_i   (read_dir_i),
        .auto_i  (auto_stop_i),
        .multi_o (cfg_multi),
        .dir_o   (dir_read_o),
        .auto_o  (cfg_auto)
    );

    xfer_seq_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .dec_i      (dec),
        .last_o     (last_blk)
    );

    xfer_seq_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .data_present_i (data_present_i),
        .multi_blk_i    (multi_blk_i),
        .count_zero_i   (blk_count_i == '0),
        .blk_done_i     (blk_done_i),
        .rsp_done_i     (cmd_rsp_done_i),
        .last_blk_i     (last_blk),
        .cfg_multi_i    (cfg_multi),
        .cfg_auto_i     (cfg_auto),
        .load_o         (load),
        .dec_o          (dec),
        .data_active_o  (data_active_o),
        .stop_req_o     (stop_req_o),
        .done_o         (xfer_done_o),
        .err_o          (start_err_o)
    );

    assign stop_idx_o = STOP_CMD_IDX;
    assign stop_arg_o = '0;
    assign stop_rsp_o = RSP_R48_BUSY;
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic read_dir_i,
    input logic blk_done_i,
    input logic cmd_rsp_done_i,
    input logic data_active_o,
    input logic dir_read_o,
    input logic stop_req_o,
    input logic xfer_done_o,
    input logic start_err_o
);
    // R6
    stop_after_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_req_o) |-> $past(blk_done_i) && $past(data_active_o));

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req_o && !cmd_rsp_done_i |=> stop_req_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_o |=> !xfer_done_o);

    // R8
    done_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_req_o) |-> xfer_done_o);

    // R10
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_err_o |-> $past(start_i)
            && ($past(data_active_o) || $past(stop_req_o) || $past(xfer_done_o)));

    // R4
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_active_o && $past(data_active_o) |-> $stable(dir_read_o));

    // R2
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({data_active_o, stop_req_o, xfer_done_o}) <= 1);
endmodule

bind xfer_seq xfer_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .read_dir_i     (read_dir_i),
    .blk_done_i     (blk_done_i),
    .cmd_rsp_done_i (cmd_rsp_done_i),
    .data_active_o  (data_active_o),
    .dir_read_o     (dir_read_o),
    .stop_req_o     (stop_req_o),
    .xfer_done_o    (xfer_done_o),
    .start_err_o    (start_err_o)
);

// File: tb/xfer_seq_test.sv
module xfer_seq_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 0, dp_i = 0, multi_i = 0, dir_i = 0, auto_i = 0;
    logic [W-1:0] cnt_i = '0;
    logic         blk_done_i = 0, rsp_i = 0;
    logic         active, dir_o, stop_req, done, err;
    logic [5:0]   idx;
    logic [31:0]  arg;
    logic [1:0]   rsp;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xfer_seq #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_present_i(dp_i),
        .multi_blk_i(multi_i), .read_dir_i(dir_i), .auto_stop_i(auto_i),
        .blk_count_i(cnt_i), .blk_done_i(blk_done_i), .cmd_rsp_done_i(rsp_i),
        .data_active_o(active), .dir_read_o(dir_o), .stop_req_o(stop_req),
        .stop_idx_o(idx), .stop_arg_o(arg), .stop_rsp_o(rsp),
        .xfer_done_o(done), .start_err_o(err)
    );

    // fields: [15]dp [14]multi [13]dir [12]auto [11:8]count
    //         [7:4]blocks expected [3]stop expected [2]data phase expected
    localparam logic [15:0] VEC [0:7] = '{
        16'h7500, 16'h8714, 16'hB914, 16'hE334,
        16'hD44C, 16'hFFFC, 16'hD000, 16'hF11C
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_start(input bit dp, input bit m, input bit d, input bit a,
                            input logic [W-1:0] c);
        dp_i = dp; multi_i = m; dir_i = d; auto_i = a; cnt_i = c;
        start_i = 1'b1;
        step();
        start_i = 1'b0;
    endtask

    task automatic pulse_blk();
        blk_done_i = 1'b1; step(); blk_done_i = 1'b0;
    endtask

    task automatic pulse_rsp();
        rsp_i = 1'b1; step(); rsp_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        step(); step();
        // R1 reset state
        chk(!active && !stop_req && !done && !err, "R1 outputs in reset", {active, stop_req, done, err}, 0);
        rst_n = 1'b1;
        step();
        chk(!active && !stop_req && !done && !err, "R1 idle after reset", {active, stop_req, done, err}, 0);

        // table walk
        for (int v = 0; v < 8; v++) begin
            logic [15:0] e;
            int nb;
            e = VEC[v];
            nb = int'(e[7:4]);
            do_start(e[15], e[14], e[13], e[12], e[11:8]);
            if (!e[2]) begin
                // R2 / R9 immediate completion
                chk(done == 1'b1, "R2 R9 immediate done", done, 1);
                chk(!active && !stop_req, "R9 no data no stop", {active, stop_req}, 0);
            end else begin
                chk(active == 1'b1, "R5 data phase active", active, 1);
                chk(dir_o == e[13], "R4 direction", dir_o, e[13]);
                dir_i = ~dir_i;
                for (int b = 0; b < nb; b++) begin
                    pulse_blk();
                    if (b < nb - 1)
                        chk(active && !done, "R3 R5 still active", active, 1);
                end
                if (e[3]) begin
                    chk(stop_req && !active && !done, "R6 stop request", stop_req, 1);
                    chk(idx == 6'd12 && arg == 0 && rsp == 2'b11, "R6 stop fields", idx, 12);
                    step(); step();
                    chk(stop_req && !done, "R6 stop held", stop_req, 1);
                    pulse_rsp();
                    chk(done && !stop_req, "R8 done after response", done, 1);
                end else begin
                    // R7: single-block with auto enabled gives no stop
                    chk(done && !stop_req && !active, "R7 R8 done no stop", {done, stop_req, active}, 4);
                end
            end
            step();
            chk(!done && !active && !stop_req, "R8 done one cycle", done, 0);
        end

        // R11 stray pulses in IDLE
        pulse_blk(); pulse_rsp();
        chk(!active && !stop_req && !done, "R11 idle stray pulses", {active, stop_req, done}, 0);
        do_start(1, 1, 0, 0, 4'd2);
        pulse_rsp();
        chk(active && !done, "R11 rsp ignored in DATA", active, 1);
        pulse_blk();
        chk(active && !done, "R11 count intact after one", active, 1);
        pulse_blk();
        chk(done, "R11 count intact done", done, 1);
        step();

        // R10 refused start during DATA and STOP
        do_start(1, 1, 1, 1, 4'd3);
        do_start(1, 0, 0, 0, 4'd1);
        chk(err == 1'b1, "R10 error pulse in DATA", err, 1);
        chk(active && dir_o == 1'b1, "R10 transfer unchanged", dir_o, 1);
        step();
        chk(err == 1'b0, "R10 error one cycle", err, 0);
        pulse_blk(); pulse_blk();
        chk(active, "R10 count unchanged", active, 1);
        pulse_blk();
        chk(stop_req, "R10 stop after original count", stop_req, 1);
        do_start(1, 1, 0, 0, 4'd1);
        chk(err && stop_req, "R10 error pulse in STOP", {err, stop_req}, 3);
        pulse_rsp();
        chk(done, "R10 done after stop", done, 1);
        step();
        chk(!err && !done, "R1 back to idle", {err, done}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule